// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt requests and presents them to a processor as two outputs: a normal interrupt and a fast interrupt. Each source can be enabled, assigned to one of the two outputs, and given a 4-bit priority. Software can also raise any source on its own through a force bit. All of this state sits behind a small 32-bit register bus.

On the normal path, the controller works out which pending source has the highest priority and reports its number and priority in a vector/status word. An interrupt handler reads that word over and over, serving each source it names, and stops when the word reads all ones. On the fast path, a second vector word names the highest-numbered pending fast source.

Sources 0 to 31 occupy the low word of every split register pair, and sources 32 to 63 occupy the high word. A read returns its data one cycle after it is requested. Writes take effect at the clock edge that accepts them. Both interrupt outputs follow the stored state and the raw inputs combinationally.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the control word, both enable words and both type words read 0, all eight priority words read 0, and the normal mask reads 0x1F.
- R2: Writing a value below 64 to offset 0x08 sets that source's enable bit, and writing it to offset 0x0C clears the bit. A value of 64 or more, written to either offset, leaves every enable bit unchanged.
- R3: Source n with n < 32 sits at bit n of the low word, and source n with n ≥ 32 sits at bit n−32 of the high word. The word pairs (high, low) are: enable at 0x10/0x14, type at 0x18/0x1C, raw source at 0x48/0x4C, force at 0x50/0x54, normal pending at 0x58/0x5C, and fast pending at 0x60/0x64.
- R4: A source is active when (raw input OR force bit) AND enable bit is true. An active source is fast-pending when its type bit is 1, and normal-pending when its type bit is 0.
- R5: Priority word x is at offset 0x20 + 4·(7−x). Source n uses word n/8, bits 4·(n mod 8) + 3 down to 4·(n mod 8).
- R6: The normal vector word at 0x40 holds the winning source number in bits 31:16 and the winner's priority in bits 15:0. The winner is the eligible normal-pending source with the highest priority; on a tie, the higher source number wins. When no source is eligible, the whole word reads 0xFFFFFFFF.
- R7: A normal-pending source is eligible when bit 4 of the mask (offset 0x04) is set, or when its priority is strictly greater than mask bits 3:0. The normal output is high exactly when some source is eligible.
- R8: The fast output is high whenever any source is fast-pending. The fast vector word at 0x44 holds the highest-numbered fast-pending source in bits 31:16 with bits 15:0 zero, or reads 0xFFFFFFFF when no source is fast-pending.
- R9: Read data appears on the cycle after the read request. It is 0 in any cycle that follows no read, and it is 0 for an unmapped offset.
- R10: A set force bit makes its source active in exactly the same way as a high raw input, whatever the level of that raw input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | 64 | Level-sensitive interrupt requests, one per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A write changes the stored state at the clock edge that accepts it. The normal and fast outputs, the pending bits and the vector words depend on that state and on `src_in` with no register in between. The bench therefore samples both outputs on the falling edge right after a write, or one time step after `src_in` changes. Read data is registered once, so each read task raises the strobe on a falling edge and samples `bus_rdata` on the next falling edge. A register value written in one task is due on the first read issued after that write.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt controller: sizes and register offsets.
package irqc_pkg;
    localparam int NSRC_DEF = 64;
    localparam int PW_DEF   = 4;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_NMASK  = 8'h04;
    localparam logic [7:0] OFS_SETNUM = 8'h08;
    localparam logic [7:0] OFS_CLRNUM = 8'h0C;
    localparam logic [7:0] OFS_ENA_H  = 8'h10;
    localparam logic [7:0] OFS_ENA_L  = 8'h14;
    localparam logic [7:0] OFS_SEL_H  = 8'h18;
    localparam logic [7:0] OFS_SEL_L  = 8'h1C;
    localparam logic [7:0] OFS_NVEC   = 8'h40;
    localparam logic [7:0] OFS_FVEC   = 8'h44;
    localparam logic [7:0] OFS_RAW_H  = 8'h48;
    localparam logic [7:0] OFS_RAW_L  = 8'h4C;
    localparam logic [7:0] OFS_FRC_H  = 8'h50;
    localparam logic [7:0] OFS_FRC_L  = 8'h54;
    localparam logic [7:0] OFS_NPD_H  = 8'h58;
    localparam logic [7:0] OFS_NPD_L  = 8'h5C;
    localparam logic [7:0] OFS_FPD_H  = 8'h60;
    localparam logic [7:0] OFS_FPD_L  = 8'h64;
endpackage

// File: rtl/irqc_regs.sv
// Register storage of the interrupt controller.
// Holds the control word, the normal mask level, and the enable, type, force
// and priority bits.
// Assumes 64 sources, split into a high word and a low word, and eight
// 32-bit priority words.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NSRC = NSRC_DEF,
    parameter int PW   = PW_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          ctrl,
    output logic [PW:0]          nmask,
    output logic [NSRC-1:0]      ena,
    output logic [NSRC-1:0]      fsel,
    output logic [NSRC-1:0]      frc,
    output logic [NSRC*PW-1:0]   prio
);
    localparam int ID_W   = $clog2(NSRC);
    localparam int HALF   = NSRC / 2;
    localparam int NWORDS = NSRC * PW / 32;

    logic       prio_hit;
    logic [2:0] prio_idx;

    // Decode a write that lands in the priority window (word 0 sits at the top address).
    always_comb begin
        prio_hit = (addr[7:5] == 3'b001) && (addr[1:0] == 2'b00);
        prio_idx = 3'(NWORDS - 1) - addr[4:2];
    end

    // Reset the state, or apply one bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            nmask <= '1;
            ena   <= '0;
            fsel  <= '0;
            frc   <= '0;
            prio  <= '0;
        end else if (wr_en) begin
            if (prio_hit) begin
                prio[prio_idx*32 +: 32] <= wdata;
            end
            case (addr)
                OFS_CTRL:   ctrl  <= wdata;
                OFS_NMASK:  nmask <= wdata[PW:0];
                OFS_SETNUM: if (wdata < 32'(NSRC)) ena[wdata[ID_W-1:0]] <= 1'b1;
                OFS_CLRNUM: if (wdata < 32'(NSRC)) ena[wdata[ID_W-1:0]] <= 1'b0;
                OFS_ENA_H:  ena[NSRC-1:HALF]  <= wdata;
                OFS_ENA_L:  ena[HALF-1:0]     <= wdata;
                OFS_SEL_H:  fsel[NSRC-1:HALF] <= wdata;
                OFS_SEL_L:  fsel[HALF-1:0]    <= wdata;
                OFS_FRC_H:  frc[NSRC-1:HALF]  <= wdata;
                OFS_FRC_L:  frc[HALF-1:0]     <= wdata;
                default: ;
            endcase
        end
    end

    // A write of a source number below the limit to the set offset turns that source on.
    assert_setnum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_SETNUM && wdata < 32'(NSRC)) |=> ena[$past(wdata[ID_W-1:0])]);

    // A write of a source number below the limit to the clear offset turns that source off.
    assert_clrnum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CLRNUM && wdata < 32'(NSRC)) |=> !ena[$past(wdata[ID_W-1:0])]);

    // A source number at or above the limit leaves the enable bits as they were.
    assert_numrange_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_SETNUM || addr == OFS_CLRNUM) && wdata >= 32'(NSRC)) |=> $stable(ena));
endmodule

// File: rtl/irqc_norm_arb.sv
// Normal-path arbiter.
// Picks the eligible pending source with the highest priority; on a tie, the
// higher source number wins.
// Assumes the priority fields are packed PW bits per source, with source 0 at
// the bottom.
module irqc_norm_arb
    import irqc_pkg::*;
#(
    parameter int NSRC = NSRC_DEF,
    parameter int PW   = PW_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      pend,
    input  logic [NSRC*PW-1:0]   prio,
    input  logic [PW:0]          nmask,
    output logic                 irq,
    output logic                 vld,
    output logic [$clog2(NSRC)-1:0] win_id,
    output logic [PW-1:0]        win_prio
);
    localparam int ID_W = $clog2(NSRC);

    logic [PW-1:0]   lvl  [NSRC];
    logic [NSRC-1:0] elig;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // Pull out this source's priority and test it against the mask level.
        always_comb begin
            lvl[g]  = prio[g*PW +: PW];
            elig[g] = pend[g] && (nmask[PW] || (lvl[g] > nmask[PW-1:0]));
        end
    end

    // Scan upward; >= lets a later (higher-numbered) source take a tie.
    always_comb begin
        vld      = 1'b0;
        win_id   = '0;
        win_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!vld || lvl[i] >= win_prio)) begin
                vld      = 1'b1;
                win_id   = ID_W'(i);
                win_prio = lvl[i];
            end
        end
        irq = |elig;
    end

    // A reported winner must itself be pending.
    assert_win_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> pend[win_id]);

    // A mask level of all ones in bits 3:0, with bit 4 clear, blocks every source.
    assert_mask_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmask == {1'b0, {PW{1'b1}}}) |-> !irq);

    // With no pending source, the normal output stays low.
    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq);
endmodule

// File: rtl/irqc_fast_pick.sv
// Fast-path selector: reports the highest-numbered fast-pending source.
// Assumes no priority applies on this path.
module irqc_fast_pick
    import irqc_pkg::*;
#(
    parameter int NSRC = NSRC_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      pend,
    output logic                 vld,
    output logic [$clog2(NSRC)-1:0] id
);
    localparam int ID_W = $clog2(NSRC);

    // Scan upward so that the last set bit wins.
    always_comb begin
        vld = 1'b0;
        id  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i]) begin
                vld = 1'b1;
                id  = ID_W'(i);
            end
        end
    end

    // The reported source must be fast-pending.
    assert_fast_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> pend[id]);
endmodule

// File: rtl/irq_vec_ctrl.sv
// Top level of the vectored prioritized interrupt controller.
// Combines the raw and forced requests, routes each source to the normal or
// the fast path, and serves register reads with one cycle of latency.
// Assumes src_in is already synchronous to clk.
module irq_vec_ctrl
    import irqc_pkg::*;
#(
    parameter int NSRC = NSRC_DEF,
    parameter int PW   = PW_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      src_in,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_o,
    output logic             fiq_o
);
    localparam int ID_W   = $clog2(NSRC);
    localparam int HALF   = NSRC / 2;
    localparam int NWORDS = NSRC * PW / 32;
    localparam int PAD    = 16 - ID_W;

    logic [31:0]        ctrl;
    logic [PW:0]        nmask;
    logic [NSRC-1:0]    ena, fsel, frc, act, npend, fpend;
    logic [NSRC*PW-1:0] prio;
    logic               n_vld, f_vld;
    logic [ID_W-1:0]    n_id, f_id;
    logic [PW-1:0]      n_prio;
    logic [31:0]        nvec, fvec, rd_mux;
    logic [2:0]         rd_pidx;

    irqc_regs #(.NSRC(NSRC), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .ctrl(ctrl), .nmask(nmask), .ena(ena), .fsel(fsel), .frc(frc), .prio(prio)
    );

    // Form the active set and split it between the two paths.
    always_comb begin
        act   = (src_in | frc) & ena;
        npend = act & ~fsel;
        fpend = act & fsel;
    end

    irqc_norm_arb #(.NSRC(NSRC), .PW(PW)) u_narb (
        .clk(clk), .rst_n(rst_n), .pend(npend), .prio(prio), .nmask(nmask),
        .irq(irq_o), .vld(n_vld), .win_id(n_id), .win_prio(n_prio)
    );

    irqc_fast_pick #(.NSRC(NSRC)) u_fpick (
        .clk(clk), .rst_n(rst_n), .pend(fpend), .vld(f_vld), .id(f_id)
    );

    // Build both vector words; all ones means nothing to report.
    always_comb begin
        fiq_o = |fpend;
        nvec  = n_vld ? {{PAD{1'b0}}, n_id, {(16-PW){1'b0}}, n_prio} : '1;
        fvec  = f_vld ? {{PAD{1'b0}}, f_id, 16'h0000} : '1;
    end

    // Select read data by offset.
    always_comb begin
        rd_pidx = 3'(NWORDS - 1) - bus_addr[4:2];
        rd_mux  = '0;
        if (bus_addr[7:5] == 3'b001 && bus_addr[1:0] == 2'b00) begin
            rd_mux = prio[rd_pidx*32 +: 32];
        end
        case (bus_addr)
            OFS_CTRL:  rd_mux = ctrl;
            OFS_NMASK: rd_mux = 32'(nmask);
            OFS_ENA_H: rd_mux = ena[NSRC-1:HALF];
            OFS_ENA_L: rd_mux = ena[HALF-1:0];
            OFS_SEL_H: rd_mux = fsel[NSRC-1:HALF];
            OFS_SEL_L: rd_mux = fsel[HALF-1:0];
            OFS_NVEC:  rd_mux = nvec;
            OFS_FVEC:  rd_mux = fvec;
            OFS_RAW_H: rd_mux = src_in[NSRC-1:HALF];
            OFS_RAW_L: rd_mux = src_in[HALF-1:0];
            OFS_FRC_H: rd_mux = frc[NSRC-1:HALF];
            OFS_FRC_L: rd_mux = frc[HALF-1:0];
            OFS_NPD_H: rd_mux = npend[NSRC-1:HALF];
            OFS_NPD_L: rd_mux = npend[HALF-1:0];
            OFS_FPD_H: rd_mux = fpend[NSRC-1:HALF];
            OFS_FPD_L: rd_mux = fpend[HALF-1:0];
            default: ;
        endcase
    end

    // Register the read data; return zero when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    // Read data is zero in any cycle that follows no read.
    assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // The fast output needs a source that is both enabled and typed fast.
    assert_fiq_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> |(ena & fsel));

    // The normal output needs a source that is both enabled and typed normal.
    assert_irq_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |(ena & ~fsel));
endmodule

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    int          total = 0, bad = 0;
    bit          done = 0;

    irq_vec_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 8'h00, 32'h0);
        rd_chk("R1 mask", 8'h04, 32'h1F);
        rd_chk("R1 enaL", 8'h14, 32'h0);
        rd_chk("R1 enaH", 8'h10, 32'h0);
        rd_chk("R1 selH", 8'h18, 32'h0);
        rd_chk("R1 prio", 8'h2C, 32'h0);
        rd_chk("R6 nvec none", 8'h40, 32'hFFFF_FFFF);
        rd_chk("R8 fvec none", 8'h44, 32'hFFFF_FFFF);
        check("R7 irq reset", 32'(irq_o), 32'h0);
        check("R8 fiq reset", 32'(fiq_o), 32'h0);
    endtask

    task automatic t_bynum;
        wr(8'h08, 32'd5);
        rd_chk("R2 set 5", 8'h14, 32'h0000_0020);
        wr(8'h08, 32'd40);
        rd_chk("R3 set 40 high", 8'h10, 32'h0000_0100);
        wr(8'h08, 32'd64);
        wr(8'h0C, 32'd100);
        rd_chk("R2 ignore hi", 8'h10, 32'h0000_0100);
        rd_chk("R2 ignore lo", 8'h14, 32'h0000_0020);
        wr(8'h0C, 32'd5);
        rd_chk("R2 clr 5", 8'h14, 32'h0);
    endtask

    task automatic t_route;
        @(negedge clk); src_in[40] = 1'b1;
        #1;
        check("R7 irq on", 32'(irq_o), 32'h1);
        check("R4 fiq off", 32'(fiq_o), 32'h0);
        rd_chk("R3 npend H", 8'h58, 32'h0000_0100);
        rd_chk("R6 nvec 40", 8'h40, 32'h0028_0000);
        wr(8'h18, 32'h0000_0100);
        check("R4 irq off", 32'(irq_o), 32'h0);
        check("R8 fiq on", 32'(fiq_o), 32'h1);
        rd_chk("R3 fpend H", 8'h60, 32'h0000_0100);
        rd_chk("R4 npend H 0", 8'h58, 32'h0);
        rd_chk("R8 fvec 40", 8'h44, 32'h0028_0000);
        rd_chk("R6 nvec empty", 8'h40, 32'hFFFF_FFFF);
        wr(8'h18, 32'h0);
        wr(8'h10, 32'h0);
        @(negedge clk); src_in = '0;
        #1;
        check("R4 idle irq", 32'(irq_o), 32'h0);
    endtask

    task automatic t_prio;
        wr(8'h54, 32'h0000_0408);          // force sources 3 and 10 (R10)
        check("R4 force no enable", 32'(irq_o), 32'h0);
        wr(8'h14, 32'h0000_0408);
        check("R10 forced irq", 32'(irq_o), 32'h1);
        wr(8'h3C, 32'h0000_5000);          // word 0: source 3 = 5
        wr(8'h38, 32'h0000_0200);          // word 1: source 10 = 2
        rd_chk("R6 higher prio wins", 8'h40, 32'h0003_0005);
        wr(8'h38, 32'h0000_0500);
        rd_chk("R5 prio word1", 8'h38, 32'h0000_0500);
        rd_chk("R6 tie higher id", 8'h40, 32'h000A_0005);
        wr(8'h04, 32'h5);
        check("R7 mask equal blocks", 32'(irq_o), 32'h0);
        rd_chk("R7 nvec masked", 8'h40, 32'hFFFF_FFFF);
        rd_chk("R4 npend under mask", 8'h5C, 32'h0000_0408);
        wr(8'h04, 32'h4);
        check("R7 mask below passes", 32'(irq_o), 32'h1);
        rd_chk("R7 nvec unmasked", 8'h40, 32'h000A_0005);
    endtask

    task automatic t_raw;
        @(negedge clk); src_in = 64'h8000_0001_0000_0002;
        rd_chk("R3 raw H", 8'h48, 32'h8000_0001);
        rd_chk("R3 raw L", 8'h4C, 32'h0000_0002);
        rd_chk("R10 frc L", 8'h54, 32'h0000_0408);
        rd_chk("R9 unmapped", 8'h80, 32'h0);
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bynum();
        t_route();
        t_prio();
        t_raw();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule